// File: doc/BRIEF.md
# Dual-Slope Ramp Interpolator Sequencer

This block is the clocked control logic for an analog time interpolator that finds where an asynchronous start event falls inside a clock period. A rising edge on `start_i` turns on the fast charging current at once, before any clock edge, so the external capacitor begins to charge from zero. The same event passes through a multi-stage synchroniser. When the synchroniser reports the event, the block turns off the fast current, turns on a slow discharge current, and latches the free-running coarse time counter. The discharge current is 1/1000 of the charge current, so the charge interval is stretched by a factor of 1000.

While the capacitor discharges, the block counts clock periods until the synchronised comparator input shows that the voltage is back at zero. That count, read against the stretch ratio, gives how far ahead of the synchroniser report the start arrived. With a 10 ns clock, one count equals 10 ps of real offset plus a fixed synchroniser latency. A count limit ends a discharge whose comparator never trips and flags the result as an error. After each result the block stays out of service for a fixed dead time, and only then accepts a new start.

Top module: `ramp_interp_ctrl`

## Requirements
- R1: While the block is idle, a rising edge on `start_i` drives `fast_charge_o` high with no clock edge in between. It stays high until the synchroniser reports the event.
- R2: Call the first rising clock edge after the start e1. With `SYNC_STAGES`=2, `fast_charge_o` falls and `slow_discharge_o` rises at the second clock edge after e1. The two are never high together.
- R3: `coarse_o` gives the value that a TIME_W-bit counter held just before the edge on which `slow_discharge_o` rose. This counter is zero at reset and increments on every rising clock edge, wrapping at its width.
- R4: `fine_o` equals the number of rising edges after `slow_discharge_o` rose, up to and including the second edge after `zero_cross_i` went high. With a 10 ns clock and stretch ratio 1000, this is ceil(100·F)+1, where F is the charge time in ns.
- R5: Only a low-to-high change of the synchronised comparator during the discharge ends the count. A comparator that is already high or that changes outside the discharge has no effect.
- R6: If the count reaches `TIMEOUT_CYC` with no comparator rise, the discharge ends. The result is reported with `timeout_o`=1 and `fine_o`=`TIMEOUT_CYC`.
- R7: If the comparator rise and the count limit land on the same edge, the rise wins: `timeout_o`=0 and `fine_o`=`TIMEOUT_CYC`.
- R8: `result_valid_o` pulses high for exactly one cycle on the edge after the discharge ends. `fine_o`, `coarse_o` and `timeout_o` change only on that edge and hold their values until the next result.
- R9: A start edge that arrives during the charge or the discharge has no effect: `fast_charge_o` stays low and the result that is in progress is unchanged.
- R10: After the edge that raises `result_valid_o`, the block ignores start edges for `DEAD_CYC` clock periods. A start edge after the `DEAD_CYC`-th edge is accepted.
- R11: During reset, all outputs are low and `fine_o` and `coarse_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Asynchronous start event, rising-edge sensitive |
| zero_cross_i | input | 1 | Asynchronous comparator, high when the capacitor is at zero |
| fast_charge_o | output | 1 | Enables the fast charging current |
| slow_discharge_o | output | 1 | Enables the slow discharge current |
| result_valid_o | output | 1 | One-cycle pulse marking a new result |
| timeout_o | output | 1 | The last result ended on the count limit |
| fine_o | output | CNT_W | Discharge count of the last result |
| coarse_o | output | TIME_W | Coarse time latched at the synchroniser report |

## Verification
Two endings of the discharge can fall on the same edge: the synchronised comparator rise and the count reaching its limit. The bench uses a smaller limit of 2600. It picks start offsets whose stretched discharge ends exactly on that limit (offset 5.985 ns) and one count past it (5.995 ns). It then checks that the first case reports a clean count of 2600 and the second reports a timeout. A sweep of start offsets across the clock period covers both sides of the limit arithmetically. A second collision, a start edge one nanosecond before the dead time ends and another just after it, is judged from the fast-charge output and from the next result.

// File: rtl/ramp_interp_pkg.sv
package ramp_interp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FAST = 2'd1,
    ST_SLOW = 2'd2,
    ST_DONE = 2'd3
  } rit_state_e;
endpackage

// File: rtl/rit_sync.sv
module rit_sync #(
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              d_i,
  output logic [STAGES-1:0] q_o
);
  logic [STAGES-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q[0] <= 1'b0;
    else         q_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q[g] <= 1'b0;
      else         q_q[g] <= q_q[g-1];
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/rit_event_latch.sv
module rit_event_latch (
  input  logic start_i,
  input  logic arm_i,
  input  logic clr_i,
  input  logic rst_ni,
  output logic evt_o
);
  logic clr_n;
  logic evt_q;

  // arm_i and clr_i come from flops, so the async clear is glitch free
  assign clr_n = rst_ni & ~clr_i;

  always_ff @(posedge start_i or negedge clr_n) begin
    if (!clr_n)     evt_q <= 1'b0;
    else if (arm_i) evt_q <= 1'b1;
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/rit_timebase.sv
module rit_timebase #(
  parameter int TIME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [TIME_W-1:0] time_o
);
  logic [TIME_W-1:0] tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= '0;
    else         tick_q <= tick_q + 1'b1;
  end

  assign time_o = tick_q;
endmodule

// File: rtl/rit_seq.sv
module rit_seq
  import ramp_interp_pkg::*;
#(
  parameter int TIMEOUT_CYC = 4000,
  parameter int DEAD_CYC    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 12,
  parameter int TIME_W      = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [SYNC_STAGES-1:0] evt_sync_i,
  input  logic                   zc_sync_i,
  input  logic [TIME_W-1:0]      time_i,
  output logic                   arm_o,
  output logic                   clr_o,
  output logic                   charge_en_o,
  output logic                   slow_o,
  output logic                   valid_o,
  output logic                   timeout_o,
  output logic [CNT_W-1:0]       fine_o,
  output logic [TIME_W-1:0]      coarse_o
);
  localparam int DEAD_W = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CNT_W-1:0]  CNT_LIMIT = CNT_W'(TIMEOUT_CYC);
  localparam logic [DEAD_W-1:0] DEAD_LAST = DEAD_W'(DEAD_CYC - 1);

  rit_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [DEAD_W-1:0] dead_q;
  logic              zc_prev_q;
  logic              zc_rise;
  logic              hit_limit;
  logic [TIME_W-1:0] coarse_hold_q;

  assign zc_rise   = zc_sync_i & ~zc_prev_q;
  assign hit_limit = (cnt_q == CNT_LIMIT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (evt_sync_i[0])             state_d = ST_FAST;
      ST_FAST: if (evt_sync_i[SYNC_STAGES-1]) state_d = ST_SLOW;
      ST_SLOW: if (zc_rise || hit_limit)      state_d = ST_DONE;
      ST_DONE: if (dead_q == DEAD_LAST)       state_d = ST_IDLE;
      default:                                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      arm_o       <= 1'b1;
      clr_o       <= 1'b0;
      charge_en_o <= 1'b1;
      slow_o      <= 1'b0;
      zc_prev_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      arm_o       <= (state_d == ST_IDLE);
      clr_o       <= (state_d == ST_DONE);
      charge_en_o <= (state_d == ST_IDLE) || (state_d == ST_FAST);
      slow_o      <= (state_d == ST_SLOW);
      zc_prev_q   <= zc_sync_i;
    end
  end

  // discharge counter; the comparator rise takes priority over the limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q         <= '0;
      coarse_hold_q <= '0;
    end else if (state_q == ST_FAST && state_d == ST_SLOW) begin
      cnt_q         <= '0;
      coarse_hold_q <= time_i;
    end else if (state_q == ST_SLOW && !zc_rise && !hit_limit) begin
      cnt_q         <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                dead_q <= '0;
    else if (state_q != ST_DONE) dead_q <= '0;
    else if (dead_q != DEAD_LAST) dead_q <= dead_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
      fine_o    <= '0;
      coarse_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (state_q == ST_SLOW && state_d == ST_DONE) begin
        valid_o   <= 1'b1;
        timeout_o <= ~zc_rise;
        fine_o    <= cnt_q;
        coarse_o  <= coarse_hold_q;
      end
    end
  end
endmodule

// File: rtl/ramp_interp_ctrl.sv
module ramp_interp_ctrl #(
  parameter int TIMEOUT_CYC = 4000,
  parameter int DEAD_CYC    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int TIME_W      = 16,
  localparam int CNT_W      = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              zero_cross_i,
  output logic              fast_charge_o,
  output logic              slow_discharge_o,
  output logic              result_valid_o,
  output logic              timeout_o,
  output logic [CNT_W-1:0]  fine_o,
  output logic [TIME_W-1:0] coarse_o
);
  logic                   evt;
  logic                   arm;
  logic                   clr;
  logic                   charge_en;
  logic [SYNC_STAGES-1:0] evt_sync;
  logic [SYNC_STAGES-1:0] zc_sync;
  logic [TIME_W-1:0]      sys_time;

  rit_event_latch u_evt (
    .start_i (start_i),
    .arm_i   (arm),
    .clr_i   (clr),
    .rst_ni  (rst_ni),
    .evt_o   (evt)
  );

  rit_sync #(.STAGES(SYNC_STAGES)) u_evt_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (evt),
    .q_o    (evt_sync)
  );

  rit_sync #(.STAGES(SYNC_STAGES)) u_zc_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (zero_cross_i),
    .q_o    (zc_sync)
  );

  rit_timebase #(.TIME_W(TIME_W)) u_time (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .time_o (sys_time)
  );

  rit_seq #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .DEAD_CYC    (DEAD_CYC),
    .SYNC_STAGES (SYNC_STAGES),
    .CNT_W       (CNT_W),
    .TIME_W      (TIME_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_sync_i  (evt_sync),
    .zc_sync_i   (zc_sync[SYNC_STAGES-1]),
    .time_i      (sys_time),
    .arm_o       (arm),
    .clr_o       (clr),
    .charge_en_o (charge_en),
    .slow_o      (slow_discharge_o),
    .valid_o     (result_valid_o),
    .timeout_o   (timeout_o),
    .fine_o      (fine_o),
    .coarse_o    (coarse_o)
  );

  // charge starts straight from the async event, before any clock edge
  assign fast_charge_o = evt & charge_en;
endmodule

// File: rtl/ramp_interp_ctrl_chk.sv
module ramp_interp_ctrl_chk #(
  parameter int TIMEOUT_CYC = 4000,
  parameter int CNT_W       = 12,
  parameter int TIME_W      = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fast_charge_o,
  input logic              slow_discharge_o,
  input logic              result_valid_o,
  input logic              timeout_o,
  input logic [CNT_W-1:0]  fine_o,
  input logic [TIME_W-1:0] coarse_o
);
  // R2
  ramps_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fast_charge_o && slow_discharge_o));

  // R2
  slow_after_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slow_discharge_o) |-> $past(fast_charge_o));

  // R8
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);

  // R8
  slow_end_reports_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(slow_discharge_o) |-> result_valid_o);

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !result_valid_o |-> ($stable(fine_o) && $stable(coarse_o) && $stable(timeout_o)));

  // R6
  timeout_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && timeout_o) |-> (fine_o == CNT_W'(TIMEOUT_CYC)));

  // R6
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_o <= CNT_W'(TIMEOUT_CYC));
endmodule

bind ramp_interp_ctrl ramp_interp_ctrl_chk #(
  .TIMEOUT_CYC (TIMEOUT_CYC),
  .CNT_W       (CNT_W),
  .TIME_W      (TIME_W)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .fast_charge_o    (fast_charge_o),
  .slow_discharge_o (slow_discharge_o),
  .result_valid_o   (result_valid_o),
  .timeout_o        (timeout_o),
  .fine_o           (fine_o),
  .coarse_o         (coarse_o)
);

// File: tb/ramp_interp_ctrl_bench.sv
`timescale 1ns/1ps
module ramp_interp_ctrl_bench;
  localparam int  TIMEOUT = 2600;
  localparam int  DEAD    = 16;
  localparam int  TIME_W  = 16;
  localparam int  CNT_W   = $clog2(TIMEOUT + 1);
  localparam real RATIO   = 1000.0;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic              zero_cross_i = 1'b1;
  logic              fast_charge_o, slow_discharge_o, result_valid_o, timeout_o;
  logic [CNT_W-1:0]  fine_o;
  logic [TIME_W-1:0] coarse_o;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;
  int cyc    = 0;

  ramp_interp_ctrl #(
    .TIMEOUT_CYC (TIMEOUT),
    .DEAD_CYC    (DEAD),
    .SYNC_STAGES (2),
    .TIME_W      (TIME_W)
  ) u_ramp_interp_ctrl (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .start_i          (start_i),
    .zero_cross_i     (zero_cross_i),
    .fast_charge_o    (fast_charge_o),
    .slow_discharge_o (slow_discharge_o),
    .result_valid_o   (result_valid_o),
    .timeout_o        (timeout_o),
    .fine_o           (fine_o),
    .coarse_o         (coarse_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    if (rst_ni) edges <= edges + 1;
    cyc <= cyc + 1;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // one measurement; off_ps = time from start to the next clock edge
  task automatic measure(input int off_ps, input bit poke_busy, input bit probe_dead);
    longint d_ps, n_cyc, exp_cnt, exp_fine, exp_err, exp_coarse;
    int     n_edges;
    realtime t0;
    bit     got;
    d_ps    = longint'(RATIO) * (20000 + off_ps);
    n_cyc   = (d_ps + 9999) / 10000;
    exp_cnt = n_cyc + 1;
    if (exp_cnt > TIMEOUT) begin exp_err = 1; exp_fine = TIMEOUT; end
    else                   begin exp_err = 0; exp_fine = exp_cnt; end

    @(posedge clk_i);
    #(10.0 - off_ps / 1000.0);
    n_edges    = edges;
    exp_coarse = (n_edges + 2) % (1 << TIME_W);
    t0 = $realtime;
    // capacitor model: charge while fast_charge_o is high, discharge 1000x slower
    fork
      begin
        realtime ts;
        @(negedge fast_charge_o);
        ts = $realtime;
        #((ts - t0) * RATIO);
        zero_cross_i = 1'b1;
      end
    join_none
    start_i = 1'b1;
    zero_cross_i = 1'b0;
    #0.2;
    check("R1 fast on at start", fast_charge_o, 1);
    #0.6 start_i = 1'b0;
    @(posedge clk_i); @(posedge clk_i); #5;
    check("R2 fast held before report", fast_charge_o, 1);
    check("R2 slow off before report", slow_discharge_o, 0);
    @(posedge clk_i); #5;
    check("R2 fast off at report", fast_charge_o, 0);
    check("R2 slow on at report", slow_discharge_o, 1);

    if (poke_busy) begin
      repeat (100) @(posedge clk_i);
      #3 start_i = 1'b1;
      #0.2;
      check("R9 start ignored while busy", fast_charge_o, 0);
      #0.5 start_i = 1'b0;
    end

    got = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_i);
      if (result_valid_o) begin got = 1; break; end
    end
    check("R8 result valid seen", got, 1);
    if (exp_err) check("R6 limit count", fine_o, exp_fine);
    else if (exp_cnt == TIMEOUT) check("R7 tie count", fine_o, exp_fine);
    else         check("R4 fine count", fine_o, exp_fine);
    if (exp_cnt == TIMEOUT) check("R7 tie no timeout", timeout_o, 0);
    else                    check("R6 timeout flag", timeout_o, exp_err);
    check("R3 coarse time", coarse_o, exp_coarse);
    @(negedge clk_i);
    check("R8 valid one cycle", result_valid_o, 0);
    check("R8 fine held", fine_o, exp_fine);

    if (probe_dead) begin
      // last ns of the dead time
      #(DEAD * 10.0 - 16.0);
      start_i = 1'b1;
      #0.2;
      check("R10 start ignored in dead time", fast_charge_o, 0);
      #0.2 start_i = 1'b0;
    end else begin
      wait (zero_cross_i == 1'b1);
      repeat (DEAD + 4) @(negedge clk_i);
    end
  endtask

  initial begin
    while (cyc < 190000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #22;
    check("R11 reset fast", fast_charge_o, 0);
    check("R11 reset slow", slow_discharge_o, 0);
    check("R11 reset valid", result_valid_o, 0);
    check("R11 reset timeout", timeout_o, 0);
    check("R11 reset fine", fine_o, 0);
    check("R11 reset coarse", coarse_o, 0);
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    // R5: comparator already high in idle must not disturb anything
    check("R5 idle comparator ignored", result_valid_o, 0);

    // sweep of offsets across the period, both sides of the limit
    for (int i = 0; i < 26; i++) measure(1007 + i * 350, i == 3, 1'b0);
    // R7: tie and one-past-tie
    measure(5985, 1'b0, 1'b0);
    measure(5995, 1'b0, 1'b0);
    // R10: start in last dead cycle ignored, next start accepted
    measure(2213, 1'b0, 1'b1);
    measure(8997, 1'b0, 1'b0);
    finish_run();
  end
endmodule